// File: doc/BRIEF.md
# USB Host Port Control and Status Logic

This block holds the per-port control bits of a USB 2.0 host controller port: the reset bit, the enable bit and the suspend bit. Software drives it through a write strobe that carries new values for reset, suspend and force-resume. A simplified line model reports back five things: that the bus reset sequence has finished, the detected speed, port power, that the controller is halted, and that suspend has taken effect. The block turns these into the readable bit values and a two-bit port state.

The readable bits do not simply echo software writes. Reset keeps reading 1 after software clears it and only drops once the line reports that the reset finished. A high-speed reset completion turns the port on without any software action. A reset that ends at another speed leaves the port disabled and raises a hand-off flag. Suspend is set only once the line confirms it. Software cannot clear suspend directly. Suspend clears when force-resume falls.

A programmable cycle deadline checks how long the port takes to settle after software clears reset. If the port has not settled in time, a sticky error is raised. The error clears when the next reset starts.

Top module: `usb_port_ctl`

## Requirements
- R1: A write with reset=1 while the reset bit reads 0 and power is on sets the reset bit from the next cycle. The same write clears enable, suspend, the hand-off flag and the deadline error.
- R2: After a write with reset=0, the reset bit keeps reading 1. It falls one cycle after the first cycle in which the line reports the reset finished, the request is clear and the controller is not halted.
- R3: While the halted input is 1, the reset bit is held at 1 even if the line reports the reset finished.
- R4: With power off, the reset, enable and suspend bits read 0 from the next cycle. A reset write made while power is off has no effect.
- R5: If the detected speed is high-speed when the reset completes, enable becomes 1 on the same edge at which the reset bit falls.
- R6: If the reset completes at any other speed, enable stays 0 and the hand-off flag is set. The flag stays set until the next reset starts.
- R7: If the reset bit is still 1 LIMIT cycles after the clearing write, the deadline error is set. A completion in exactly the LIMIT-th cycle does not set it. The error stays set until the next reset starts.
- R8: The port state is encoded as 2'b00 disabled (enable=0, suspend ignored), 2'b01 enabled (enable=1, suspend=0) and 2'b10 suspended (enable=1, suspend=1).
- R9: A write of suspend=1 while enabled and not in reset does not change the suspend bit at once. The bit reads 1 starting the cycle after the line reports suspend complete.
- R10: A write of suspend=0 leaves the suspend bit unchanged. A write of suspend=1 while the port is disabled is ignored, and the suspend bit stays 0.
- R11: A write that takes force-resume from 1 to 0 clears the suspend bit from the next cycle.
- R12: The downstream-traffic permit is 1 only while the port is enabled, not suspended and not in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_reset | input | 1 | Written value of the reset bit |
| wr_suspend | input | 1 | Written value of the suspend bit |
| wr_resume | input | 1 | Written value of the force-resume bit |
| line_reset_done | input | 1 | Line reports the bus reset sequence finished |
| line_hs | input | 1 | Line detected a high-speed device |
| port_power | input | 1 | Port power is on |
| ctrl_halted | input | 1 | Controller is halted |
| line_suspended | input | 1 | Line reports suspend has taken effect |
| rd_reset | output | 1 | Readable reset bit |
| rd_enable | output | 1 | Readable enable bit |
| rd_suspend | output | 1 | Readable suspend bit |
| port_state | output | 2 | 00 disabled, 01 enabled, 10 suspended |
| downstream_ok | output | 1 | Downstream traffic permitted |
| handoff | output | 1 | Last reset ended at a speed other than high-speed |
| deadline_err | output | 1 | Reset did not settle within LIMIT cycles |

## Verification
Every readable result comes from a register. A software write or a line event therefore shows up one edge later, and the bench samples it on the falling edge that follows that rising edge. The completion delay is swept from zero to past LIMIT cycles for both speeds. Under this timing a completion reported d cycles after the clearing write takes effect at edge d+1, so the bench expects the deadline error exactly when d is at least LIMIT. Hold, power-off, suspend and force-resume cases are each checked on the falling edge after the edge they are due at. Where a write must be ignored, the affected bit is also checked on that same falling edge.

// File: rtl/usb_port_ctl.sv
module usb_port_ctl #(
  parameter int LIMIT = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_reset,
  input  logic       wr_suspend,
  input  logic       wr_resume,
  input  logic       line_reset_done,
  input  logic       line_hs,
  input  logic       port_power,
  input  logic       ctrl_halted,
  input  logic       line_suspended,
  output logic       rd_reset,
  output logic       rd_enable,
  output logic       rd_suspend,
  output logic [1:0] port_state,
  output logic       downstream_ok,
  output logic       handoff,
  output logic       deadline_err
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [1:0] ST_DIS = 2'b00, ST_EN = 2'b01, ST_SUSP = 2'b10;

  logic          sw_req, busy, en, susp, pend, fr, ho, err;
  logic [CW-1:0] cnt;

  wire rst_start = wr_en & wr_reset & ~sw_req;
  wire rst_clear = wr_en & ~wr_reset & sw_req;
  wire rst_done  = busy & ~sw_req & line_reset_done & ~ctrl_halted;
  wire fr_fall   = wr_en & ~wr_resume & fr;
  wire susp_req  = wr_en & wr_suspend & en & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !port_power) begin
      sw_req <= 1'b0; busy <= 1'b0; en <= 1'b0; susp <= 1'b0;
      pend <= 1'b0; fr <= 1'b0; ho <= 1'b0; err <= 1'b0; cnt <= '0;
    end else begin
      if (wr_en) fr <= wr_resume;
      if (rst_start) begin
        sw_req <= 1'b1; busy <= 1'b1; en <= 1'b0; susp <= 1'b0;
        pend <= 1'b0; ho <= 1'b0; err <= 1'b0; cnt <= '0;
      end else begin
        if (rst_clear) begin
          sw_req <= 1'b0;
          cnt    <= '0;
        end else if (busy && !sw_req && !rst_done && !err) begin
          if (cnt == CW'(LIMIT - 1)) err <= 1'b1;
          else cnt <= cnt + CW'(1);
        end
        if (rst_done) begin
          busy <= 1'b0;
          en   <= line_hs;
          ho   <= ~line_hs;
        end
        if (fr_fall) begin
          susp <= 1'b0;
          pend <= 1'b0;
        end else begin
          if (susp_req) pend <= 1'b1;
          if (pend && en && line_suspended) begin
            susp <= 1'b1;
            pend <= 1'b0;
          end
        end
      end
    end
  end

  assign rd_reset      = busy;
  assign rd_enable     = en;
  assign rd_suspend    = susp;
  assign handoff       = ho;
  assign deadline_err  = err;
  assign port_state    = !en ? ST_DIS : (susp ? ST_SUSP : ST_EN);
  assign downstream_ok = en & ~susp & ~busy;

  a_r2_reset_lags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_reset) |-> $past(!port_power || (line_reset_done && !ctrl_halted)));
  a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reset && ctrl_halted && port_power && !(wr_en && wr_reset)) |=> (rd_reset || !port_power));
  a_r4_power_off: assert property (@(posedge clk) disable iff (!rst_n)
    !port_power |=> (!rd_reset && !rd_enable && !rd_suspend));
  a_r5_hs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_enable) |-> $past(line_hs && line_reset_done));
  a_r8_susp_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    rd_suspend |-> rd_enable);
  a_r9_susp_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_suspend) |-> $past(line_suspended));
  a_r11_susp_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_suspend) |-> $past(fr_fall || rst_start || !port_power));
endmodule

// File: tb/tb_usb_port_ctl.sv
`timescale 1ns/1ps
module tb_usb_port_ctl;
  localparam int LIMIT = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_reset = 0, wr_suspend = 0, wr_resume = 0;
  logic line_reset_done = 0, line_hs = 0, port_power = 0, ctrl_halted = 0, line_suspended = 0;
  logic rd_reset, rd_enable, rd_suspend, downstream_ok, handoff, deadline_err;
  logic [1:0] port_state;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  usb_port_ctl #(.LIMIT(LIMIT)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic r, input logic s, input logic f);
    @(negedge clk);
    wr_en = 1; wr_reset = r; wr_suspend = s; wr_resume = f;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_reset(input logic hs);
    line_hs = hs;
    wr(1, 0, 0);
    wr(0, 0, 0);
    line_reset_done = 1;
    @(negedge clk);
    line_reset_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset state", port_state, 0);
    chk("R1 reset bit idle", rd_reset, 0);
    chk("R7 err idle", deadline_err, 0);
    rst_n = 1;
    port_power = 1;
    @(negedge clk);

    for (int hs = 0; hs < 2; hs++) begin
      for (int d = 0; d <= LIMIT + 2; d++) begin
        line_hs = hs[0];
        wr(1, 0, 0);
        chk("R1 reset set", rd_reset, 1);
        chk("R1 enable cleared", rd_enable, 0);
        chk("R7 err cleared on start", deadline_err, 0);
        chk("R6 handoff cleared", handoff, 0);
        chk("R12 no traffic in reset", downstream_ok, 0);
        wr(0, 0, 0);
        chk("R2 reset lags clear", rd_reset, 1);
        repeat (d) @(negedge clk);
        chk("R2 still in reset", rd_reset, 1);
        line_reset_done = 1;
        @(negedge clk);
        line_reset_done = 0;
        chk("R2 reset fell", rd_reset, 0);
        chk("R5 enable on hs", rd_enable, hs);
        chk("R6 handoff", handoff, 1 - hs);
        chk("R7 deadline", deadline_err, (d >= LIMIT) ? 1 : 0);
        chk("R8 state", port_state, hs);
        chk("R12 traffic", downstream_ok, hs);
        @(negedge clk);
        chk("R7 err sticky", deadline_err, (d >= LIMIT) ? 1 : 0);
      end
    end

    line_hs = 1;
    wr(1, 0, 0);
    ctrl_halted = 1;
    wr(0, 0, 0);
    line_reset_done = 1;
    repeat (3) @(negedge clk);
    chk("R3 held while halted", rd_reset, 1);
    ctrl_halted = 0;
    @(negedge clk);
    line_reset_done = 0;
    chk("R3 released", rd_reset, 0);
    chk("R5 enabled after hold", rd_enable, 1);

    wr(0, 1, 0);
    chk("R9 suspend not yet", rd_suspend, 0);
    chk("R8 still enabled", port_state, 1);
    line_suspended = 1;
    @(negedge clk);
    chk("R9 suspend set", rd_suspend, 1);
    chk("R8 suspended code", port_state, 2);
    chk("R12 no traffic suspended", downstream_ok, 0);
    wr(0, 0, 0);
    chk("R10 zero write ignored", rd_suspend, 1);
    wr(0, 1, 1);
    chk("R11 resume high keeps", rd_suspend, 1);
    wr(0, 0, 0);
    chk("R11 resume fall clears", rd_suspend, 0);
    chk("R8 back to enabled", port_state, 1);
    line_suspended = 0;

    do_reset(0);
    chk("R6 disabled after fs", port_state, 0);
    wr(0, 1, 0);
    line_suspended = 1;
    repeat (2) @(negedge clk);
    chk("R10 disabled suspend ignored", rd_suspend, 0);
    chk("R10 state disabled", port_state, 0);
    line_suspended = 0;

    do_reset(1);
    wr(0, 1, 0);
    line_suspended = 1;
    @(negedge clk);
    line_suspended = 0;
    chk("R9 suspended before power off", rd_suspend, 1);
    port_power = 0;
    @(negedge clk);
    chk("R4 enable off", rd_enable, 0);
    chk("R4 suspend off", rd_suspend, 0);
    chk("R8 state off", port_state, 0);
    wr(1, 0, 0);
    chk("R4 reset write ignored", rd_reset, 0);
    wr(0, 0, 0);
    port_power = 1;
    wr(1, 0, 0);
    chk("R1 reset after power", rd_reset, 1);
    port_power = 0;
    @(negedge clk);
    chk("R4 reset drops", rd_reset, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule